// File: doc/BRIEF.md
# Maskable interrupt request controller

This block collects interrupt events from up to sixteen sources, holds each one in a request bit, and offers the CPU core a single accepted interrupt together with the index of the source that won. Each source has a software-writable enable bit. A global disable flag sits above all the enable bits, and software sets or clears that flag with one-cycle strobes. When the core acknowledges the offered interrupt, the winning request bit clears and the disable flag sets. Software must clear the flag again if it wants nested interrupts.

External pins and two counter pins reach the request bits through two-flop synchronizers. A per-pin polarity bit decides whether a rising or a falling edge raises the request. The two counter pins share one request bit. A select bit in the polarity register decides which of the two counter pins drives that shared request. On-chip peripherals raise their requests through synchronous event pulses.

Software reaches the state through a byte-wide register bus with five fixed addresses. Request bits can only be cleared from the bus and can never be set from it. A write of 1 to a request bit has no effect. Read data is registered.

Top module: `irq_accept_ctrl`

## Requirements
- R1: After reset, every request, enable and polarity bit reads 0, the disable flag is 1, and `irq_o` is 0.
- R2: An event pulse on `evt_i[k]` sets request bit k at the same clock edge. The bit then stays 1 until it is acknowledged or cleared from the bus.
- R3: Writing a 0 to a request bit at 0xFC (sources 7..0) or 0xFD (sources 15..8) clears that bit. Writing a 1 to a request bit leaves it unchanged.
- R4: Enable bits at 0xFE (sources 7..0) and 0xFF (sources 15..8) read back exactly what was written.
- R5: A request whose enable bit is 0 still sets its request bit, but it is not offered. It stays pending until it is cleared or its enable bit is set.
- R6: `irq_o` is 1 exactly when some request bit and its enable bit are both 1 and the disable flag is 0. It is registered from the next-state values, so it changes at the same edge as the bit that caused the change.
- R7: When several enabled requests are pending, `irq_id_o` names the lowest-numbered one.
- R8: A one-cycle `irq_ack_i` clears the request bit named by `irq_id_o` and sets the disable flag. `irq_o` falls at that same edge.
- R9: `dis_set_i` sets the disable flag and `dis_clr_i` clears it. If both strobes are high in one cycle, or a clear arrives together with an acknowledge, the flag ends up 1.
- R10: External pin j raises request j on a rising edge when polarity bit j at 0xFB is 0, and on a falling edge when that bit is 1. The edge of the other direction raises nothing.
- R11: The shared counter request is source 2. Polarity bit 2 applies to counter pin 0 and polarity bit 3 to counter pin 1. Bit 4 at 0xFB chooses the source pin: 0 selects counter pin 0 and 1 selects counter pin 1. Edges on the unselected pin raise nothing.
- R12: When a new event for a source arrives in the same cycle as a bus clear or an acknowledge of that source, the request bit stays 1.
- R13: A read returns the addressed register on `bus_rdata` one cycle after `bus_re`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| evt_i | input | 16 | Synchronous event pulses, one per source |
| xpin_i | input | 2 | Asynchronous external interrupt pins (sources 0 and 1) |
| cnt_pin_i | input | 2 | Asynchronous counter pins sharing source 2 |
| dis_set_i | input | 1 | Strobe that sets the disable flag |
| dis_clr_i | input | 1 | Strobe that clears the disable flag |
| irq_ack_i | input | 1 | One-cycle acknowledge from the core |
| irq_o | output | 1 | Interrupt offered to the core |
| irq_id_o | output | 4 | Index of the offered source |
| dis_flag_o | output | 1 | Global disable flag |

## Verification
The bound checker examines every cycle for several properties. It confirms that an offered interrupt always matches an enabled pending request while the flag is clear, with no lower-numbered contender. It confirms that an acknowledge leaves the flag set and the offer withdrawn, that the strobes move the flag as required, and that no request bit falls unless a bus write or an acknowledge preceded it. Some behaviours only the directed scenarios can show: pin edges under each polarity, routing of the counter select, the set-over-clear race, register read-back, and that writing 1 has no effect.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  localparam int unsigned BUS_AW = 8;
  localparam int unsigned BUS_DW = 8;

  // register map
  localparam logic [BUS_AW-1:0] ADDR_POL      = 8'hFB;
  localparam logic [BUS_AW-1:0] ADDR_REQ_BASE = 8'hFC;
  localparam logic [BUS_AW-1:0] ADDR_EN_BASE  = 8'hFE;

  // polarity register bit that routes one counter pin to the shared source
  localparam int unsigned CNT_SEL_BIT = 4;

  // index of lowest set bit, 0 if none
  function automatic logic [7:0] lowest_set(input logic [255:0] v, input int unsigned n);
    logic [7:0] idx;
    idx = '0;
    for (int i = n - 1; i >= 0; i--) begin
      if (v[i]) idx = 8'(i);
    end
    return idx;
  endfunction

endpackage

// File: rtl/irqc_edge_det.sv
module irqc_edge_det #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pin_i,
  input  logic [W-1:0] falling_i,
  output logic [W-1:0] edge_o
);

  for (genvar g = 0; g < W; g++) begin : g_pin
    logic s1_q, s2_q, prev_q;
    logic cur_n, prev_n;

    always_ff @(posedge clk) begin
      if (rst) begin
        s1_q   <= 1'b0;
        s2_q   <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        s1_q   <= pin_i[g];
        s2_q   <= s1_q;
        prev_q <= s2_q;
      end
    end

    // both samples pass through the current polarity, so a polarity
    // change alone never looks like an edge
    always_comb begin
      cur_n     = s2_q ^ falling_i[g];
      prev_n    = prev_q ^ falling_i[g];
      edge_o[g] = cur_n & ~prev_n;
    end
  end

endmodule

// File: rtl/irqc_req_bank.sv
module irqc_req_bank
  import irqc_pkg::*;
#(
  parameter int unsigned NSRC = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [BUS_AW-1:0] addr,
  input  logic [BUS_DW-1:0] wdata,
  input  logic [NSRC-1:0]   set_vec,
  input  logic [NSRC-1:0]   ack_vec,
  output logic [NSRC-1:0]   req_q,
  output logic [NSRC-1:0]   en_q,
  output logic [NSRC-1:0]   req_d,
  output logic [NSRC-1:0]   en_d
);

  localparam int unsigned NBYTE = (NSRC + BUS_DW - 1) / BUS_DW;
  localparam int unsigned PADW  = NBYTE * BUS_DW;

  logic [PADW-1:0] sw_clr;
  logic [PADW-1:0] en_wr_val;
  logic [PADW-1:0] en_wr_hit;

  for (genvar b = 0; b < NBYTE; b++) begin : g_byte
    logic hit_req, hit_en;
    always_comb begin
      hit_req = we && (addr == BUS_AW'(ADDR_REQ_BASE + b));
      hit_en  = we && (addr == BUS_AW'(ADDR_EN_BASE + b));
      sw_clr[b*BUS_DW +: BUS_DW]    = hit_req ? ~wdata : '0;
      en_wr_val[b*BUS_DW +: BUS_DW] = wdata;
      en_wr_hit[b*BUS_DW +: BUS_DW] = {BUS_DW{hit_en}};
    end
  end

  always_comb begin
    // a new event beats any clear in the same cycle
    req_d = (req_q & ~sw_clr[NSRC-1:0] & ~ack_vec) | set_vec;
    en_d  = (en_q & ~en_wr_hit[NSRC-1:0]) | (en_wr_val[NSRC-1:0] & en_wr_hit[NSRC-1:0]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= '0;
      en_q  <= '0;
    end else begin
      req_q <= req_d;
      en_q  <= en_d;
    end
  end

endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter
  import irqc_pkg::*;
#(
  parameter int unsigned NSRC = 16,
  localparam int unsigned IDW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] req_d,
  input  logic [NSRC-1:0] en_d,
  input  logic            dis_set,
  input  logic            dis_clr,
  input  logic            ack,
  output logic [NSRC-1:0] ack_vec,
  output logic            irq_q,
  output logic [IDW-1:0]  id_q,
  output logic            dis_q
);

  logic            dis_d;
  logic [NSRC-1:0] live;
  logic [255:0]    live_wide;

  always_comb begin
    ack_vec = '0;
    if (ack) ack_vec[id_q] = 1'b1;
  end

  always_comb begin
    if (dis_set || ack)  dis_d = 1'b1;
    else if (dis_clr)    dis_d = 1'b0;
    else                 dis_d = dis_q;
    live      = req_d & en_d;
    live_wide = '0;
    live_wide[NSRC-1:0] = live;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dis_q <= 1'b1;
      irq_q <= 1'b0;
      id_q  <= '0;
    end else begin
      dis_q <= dis_d;
      irq_q <= (|live) & ~dis_d;
      id_q  <= IDW'(lowest_set(live_wide, NSRC));
    end
  end

endmodule

// File: rtl/irq_accept_ctrl.sv
module irq_accept_ctrl
  import irqc_pkg::*;
#(
  parameter int unsigned NSRC    = 16,
  parameter int unsigned NPIN    = 2,
  parameter int unsigned CNT_SRC = 2,
  localparam int unsigned IDW    = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [7:0]        bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [NSRC-1:0]   evt_i,
  input  logic [NPIN-1:0]   xpin_i,
  input  logic [1:0]        cnt_pin_i,
  input  logic              dis_set_i,
  input  logic              dis_clr_i,
  input  logic              irq_ack_i,
  output logic              irq_o,
  output logic [IDW-1:0]    irq_id_o,
  output logic              dis_flag_o
);

  localparam int unsigned NEDGE = NPIN + 2;
  localparam int unsigned NBYTE = (NSRC + BUS_DW - 1) / BUS_DW;
  localparam int unsigned PADW  = NBYTE * BUS_DW;

  // polarity bits: [NPIN-1:0] pins, NPIN and NPIN+1 counters; select bit fixed
  logic [BUS_DW-1:0] pol_q;
  logic [NEDGE-1:0]  edges;
  logic [NSRC-1:0]   pin_set;
  logic [NSRC-1:0]   set_vec;
  logic [NSRC-1:0]   ack_vec;
  logic [NSRC-1:0]   req_q, en_q, req_d, en_d;
  logic              cnt_edge;

  always_ff @(posedge clk) begin
    if (rst)                                pol_q <= '0;
    else if (bus_we && bus_addr == ADDR_POL) pol_q <= bus_wdata;
  end

  irqc_edge_det #(.W(NEDGE)) u_edge (
    .clk      (clk),
    .rst      (rst),
    .pin_i    ({cnt_pin_i, xpin_i}),
    .falling_i(pol_q[NEDGE-1:0]),
    .edge_o   (edges)
  );

  always_comb begin
    cnt_edge = pol_q[CNT_SEL_BIT] ? edges[NPIN+1] : edges[NPIN];
    pin_set  = '0;
    for (int i = 0; i < NPIN; i++) pin_set[i] = edges[i];
    pin_set[CNT_SRC] = pin_set[CNT_SRC] | cnt_edge;
    set_vec = evt_i | pin_set;
  end

  irqc_req_bank #(.NSRC(NSRC)) u_bank (
    .clk    (clk),
    .rst    (rst),
    .we     (bus_we),
    .addr   (bus_addr),
    .wdata  (bus_wdata),
    .set_vec(set_vec),
    .ack_vec(ack_vec),
    .req_q  (req_q),
    .en_q   (en_q),
    .req_d  (req_d),
    .en_d   (en_d)
  );

  irqc_arbiter #(.NSRC(NSRC)) u_arb (
    .clk    (clk),
    .rst    (rst),
    .req_d  (req_d),
    .en_d   (en_d),
    .dis_set(dis_set_i),
    .dis_clr(dis_clr_i),
    .ack    (irq_ack_i),
    .ack_vec(ack_vec),
    .irq_q  (irq_o),
    .id_q   (irq_id_o),
    .dis_q  (dis_flag_o)
  );

  // registered read path
  logic [PADW-1:0] req_pad, en_pad;
  logic [7:0]      rd_mux;

  always_comb begin
    req_pad = '0;
    en_pad  = '0;
    req_pad[NSRC-1:0] = req_q;
    en_pad[NSRC-1:0]  = en_q;
    rd_mux = '0;
    if (bus_addr == ADDR_POL) rd_mux = pol_q;
    for (int b = 0; b < NBYTE; b++) begin
      if (bus_addr == BUS_AW'(ADDR_REQ_BASE + b)) rd_mux = req_pad[b*BUS_DW +: BUS_DW];
      if (bus_addr == BUS_AW'(ADDR_EN_BASE + b))  rd_mux = en_pad[b*BUS_DW +: BUS_DW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_re) bus_rdata <= rd_mux;
    else             bus_rdata <= '0;
  end

endmodule

// File: rtl/irq_accept_ctrl_chk.sv
module irq_accept_ctrl_chk #(
  parameter int unsigned NSRC = 16,
  parameter int unsigned IDW  = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            bus_we,
  input logic            dis_set_i,
  input logic            dis_clr_i,
  input logic            irq_ack_i,
  input logic            irq_o,
  input logic [IDW-1:0]  irq_id_o,
  input logic            dis_flag_o,
  input logic [NSRC-1:0] req_q,
  input logic [NSRC-1:0] en_q
);

  logic [NSRC-1:0] live;
  logic [NSRC-1:0] below;

  always_comb begin
    live  = req_q & en_q;
    below = '0;
    for (int i = 0; i < NSRC; i++) below[i] = (i < int'(irq_id_o));
  end

  // R6: offer only while the flag is clear and something enabled is pending
  a_r6_offer_valid: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (!dis_flag_o && live[irq_id_o]));

  // R7: nothing enabled below the offered index
  a_r7_lowest_wins: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> ((live & below) == '0));

  // R8: acknowledge sets the flag and withdraws the offer
  a_r8_ack_effect: assert property (@(posedge clk) disable iff (rst)
    irq_ack_i |=> (dis_flag_o && !irq_o));

  // R9: set strobe wins, clear alone clears
  a_r9_set_strobe: assert property (@(posedge clk) disable iff (rst)
    dis_set_i |=> dis_flag_o);

  a_r9_clr_strobe: assert property (@(posedge clk) disable iff (rst)
    (dis_clr_i && !dis_set_i && !irq_ack_i) |=> !dis_flag_o);

  // R2: a request bit falls only after a bus write or an acknowledge
  a_r2_req_holds: assert property (@(posedge clk) disable iff (rst)
    (!bus_we && !irq_ack_i) |=> ((req_q & ~$past(req_q)) == req_q - (req_q & $past(req_q)) &&
                                 ($past(req_q) & ~req_q) == '0));

endmodule

bind irq_accept_ctrl irq_accept_ctrl_chk #(.NSRC(NSRC), .IDW(IDW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_we    (bus_we),
  .dis_set_i (dis_set_i),
  .dis_clr_i (dis_clr_i),
  .irq_ack_i (irq_ack_i),
  .irq_o     (irq_o),
  .irq_id_o  (irq_id_o),
  .dis_flag_o(dis_flag_o),
  .req_q     (req_q),
  .en_q      (en_q)
);

// File: tb/sim_irq_accept_ctrl.sv
module sim_irq_accept_ctrl;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 0, bus_re = 0;
  logic [7:0]  bus_addr = 0, bus_wdata = 0;
  logic [7:0]  bus_rdata;
  logic [15:0] evt_i = 0;
  logic [1:0]  xpin_i = 0, cnt_pin_i = 0;
  logic        dis_set_i = 0, dis_clr_i = 0, irq_ack_i = 0;
  logic        irq_o;
  logic [3:0]  irq_id_o;
  logic        dis_flag_o;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  irq_accept_ctrl u0 (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_i(evt_i), .xpin_i(xpin_i), .cnt_pin_i(cnt_pin_i),
    .dis_set_i(dis_set_i), .dis_clr_i(dis_clr_i), .irq_ack_i(irq_ack_i),
    .irq_o(irq_o), .irq_id_o(irq_id_o), .dis_flag_o(dis_flag_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd_check(input string req, input logic [7:0] a, input logic [7:0] exp);
    bus_re = 1; bus_addr = a;
    @(negedge clk);
    bus_re = 0;
    check(req, bus_rdata, exp);
  endtask

  task automatic pulse_evt(input logic [15:0] v);
    evt_i = v;
    @(negedge clk);
    evt_i = 0;
  endtask

  task automatic strobe(input logic s, input logic c);
    dis_set_i = s; dis_clr_i = c;
    @(negedge clk);
    dis_set_i = 0; dis_clr_i = 0;
  endtask

  task automatic ack();
    irq_ack_i = 1;
    @(negedge clk);
    irq_ack_i = 0;
  endtask

  task automatic settle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clean();
    strobe(1, 0);
    wr(8'hFE, 0); wr(8'hFF, 0);
    wr(8'hFC, 0); wr(8'hFD, 0);
    wr(8'hFB, 0);
  endtask

  task automatic t_reset();
    check("R1 irq", irq_o, 0);
    check("R1 dis", dis_flag_o, 1);
    rd_check("R1 R13 pol", 8'hFB, 0);
    rd_check("R1 R13 reqlo", 8'hFC, 0);
    rd_check("R1 R13 reqhi", 8'hFD, 0);
    rd_check("R1 R13 enlo", 8'hFE, 0);
    rd_check("R1 R13 enhi", 8'hFF, 0);
  endtask

  task automatic t_enable_rw();
    wr(8'hFE, 8'hA5); wr(8'hFF, 8'h3C);
    rd_check("R4 enlo", 8'hFE, 8'hA5);
    rd_check("R4 enhi", 8'hFF, 8'h3C);
    clean();
  endtask

  task automatic t_pending();
    strobe(0, 1);
    check("R9 clr", dis_flag_o, 0);
    pulse_evt(16'h0020);
    rd_check("R2 R5 pend", 8'hFC, 8'h20);
    settle(3);
    check("R5 not offered", irq_o, 0);
    wr(8'hFE, 8'h20);
    check("R6 offer", irq_o, 1);
    check("R6 id", irq_id_o, 5);
    wr(8'hFC, 8'hFF);
    rd_check("R3 write one", 8'hFC, 8'h20);
    check("R3 still offered", irq_o, 1);
    wr(8'hFC, 8'hDF);
    check("R3 clr drop", irq_o, 0);
    rd_check("R3 cleared", 8'hFC, 8'h00);
    clean();
  endtask

  task automatic t_priority();
    wr(8'hFE, 8'hFF); wr(8'hFF, 8'hFF);
    pulse_evt(16'h0208);
    strobe(0, 1);
    check("R7 irq", irq_o, 1);
    check("R7 lowest", irq_id_o, 3);
    ack();
    check("R8 irq drop", irq_o, 0);
    check("R8 dis set", dis_flag_o, 1);
    rd_check("R8 lo cleared", 8'hFC, 8'h00);
    rd_check("R8 hi kept", 8'hFD, 8'h02);
    strobe(0, 1);
    check("R7 next id", irq_id_o, 9);
    // acknowledge while the same source fires again
    irq_ack_i = 1; evt_i = 16'h0200;
    @(negedge clk);
    irq_ack_i = 0; evt_i = 0;
    rd_check("R12 ack race", 8'hFD, 8'h02);
    check("R8 dis after ack", dis_flag_o, 1);
    clean();
  endtask

  task automatic t_strobes();
    strobe(0, 1);
    check("R9 clr", dis_flag_o, 0);
    strobe(1, 1);
    check("R9 both", dis_flag_o, 1);
    strobe(0, 1);
    strobe(1, 0);
    check("R9 set", dis_flag_o, 1);
  endtask

  task automatic t_pins();
    xpin_i[0] = 1; settle(5);
    rd_check("R10 rise pol0", 8'hFC, 8'h01);
    xpin_i[0] = 0; settle(5);
    wr(8'hFC, 0);
    rd_check("R10 fall ignored", 8'hFC, 8'h00);
    wr(8'hFB, 8'h02);
    xpin_i[1] = 1; settle(5);
    rd_check("R10 rise ignored pol1", 8'hFC, 8'h00);
    xpin_i[1] = 0; settle(5);
    rd_check("R10 fall pol1", 8'hFC, 8'h02);
    clean();
  endtask

  task automatic t_counter();
    cnt_pin_i[1] = 1; settle(5);
    rd_check("R11 unselected cnt1", 8'hFC, 8'h00);
    cnt_pin_i[1] = 0; settle(5);
    cnt_pin_i[0] = 1; settle(5);
    rd_check("R11 cnt0 selected", 8'hFC, 8'h04);
    wr(8'hFC, 0);
    wr(8'hFB, 8'h10);
    cnt_pin_i[0] = 0; settle(5);
    cnt_pin_i[0] = 1; settle(5);
    rd_check("R11 unselected cnt0", 8'hFC, 8'h00);
    cnt_pin_i[1] = 1; settle(5);
    rd_check("R11 cnt1 selected", 8'hFC, 8'h04);
    cnt_pin_i = 0; settle(5);
    clean();
  endtask

  task automatic t_race();
    pulse_evt(16'h0080);
    bus_we = 1; bus_addr = 8'hFC; bus_wdata = 8'h00; evt_i = 16'h0080;
    @(negedge clk);
    bus_we = 0; evt_i = 0;
    rd_check("R12 sw race", 8'hFC, 8'h80);
    clean();
  endtask

  initial begin
    settle(3);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_enable_rw();
    t_pending();
    t_priority();
    t_strobes();
    t_pins();
    t_counter();
    t_race();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule